// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Controller

This block is the host side of the handshake that takes a bidirectional parallel port out of plain compatibility mode into an enhanced transfer mode, and the handshake that brings it back. A start request carries an 8-bit mode code. The controller places that code on the data lines and steps the four host control lines through the negotiation events. It then samples the five peripheral status lines and decides whether the peripheral accepted. A terminate request runs the two-stage return handshake. Whatever the outcome, the port then ends in compatibility mode with the host driving the data bus.

All waits are measured in ticks. A single prescaler makes the ticks, and its period is set by the `tick_div` input, at `tick_div + 1` clock cycles per tick. Every finished operation gives a one-cycle `done` pulse and a result code. The result code stays valid until the next `done`. The `enh_active` and `active_code` outputs show the mode that is currently in force. The data transfer phases, the register interface and DMA belong to other blocks.

Top module: `ppm_negotiator`

## Requirements
- R1: After reset, n_strobe, n_autofd and n_init are 1, n_selectin is 0, data_out is 0x00, and busy, done and enh_active are 0.
- R2: If a start request arrives while idle and n_selectin is already 1, done pulses in the next cycle with result 5 (refused). The control lines do not change and the mode does not change.
- R3: An accepted start request puts mode_code on data_out in the first busy cycle and holds the control lines in their idle levels for one tick. Exactly tick_div+1 cycles later, n_selectin rises to 1 and n_autofd falls to 0, while n_strobe and n_init stay at 1.
- R4: After n_selectin rises, the controller waits for st_perror, st_select and st_nfault all 1 with st_nack 0. If that is not seen within 6 ticks, done pulses exactly 6·(tick_div+1) cycles after the rise, with result 3 (timeout), and the control lines return to their idle levels.
- R5: The status match is seen in cycle c. From the cycle after c, n_strobe is 0 for exactly one tick, with n_selectin 1 and n_autofd 0. Then n_strobe and n_autofd both go to 1 together.
- R6: After n_strobe returns to 1, the controller waits up to 7 ticks for st_nack to be 1. If the wait expires, done pulses 7·(tick_div+1) cycles after the rise, with result 4 (protocol error), and the control lines return to idle.
- R7: In the cycle where st_nack is seen at 1, mode code 0x00 is always accepted, and any other code is accepted only if st_select is 1 in that same cycle. On acceptance, done pulses one cycle later with result 1 (ok), enh_active becomes 1, active_code takes the code, and n_selectin stays at 1. On rejection, the result is 2 (rejected) and the lines return to idle.
- R8: A terminate request drives n_selectin 0 with n_autofd, n_strobe and n_init at 1. The controller then waits up to 7 ticks for st_busy and st_nfault at 1 with st_nack at 0. On expiry, done pulses 7·(tick_div+1) cycles after the request is taken, with result 4.
- R9: When that status is seen, n_autofd goes to 0 in the next cycle, and the controller waits up to 6 ticks for st_nack at 1. It then raises n_autofd, and the result is 1 on success or 4 on expiry. On expiry, done pulses 6·(tick_div+1) cycles after n_autofd fell. In both cases n_autofd is 1 at done.
- R10: Every terminate operation, whether it succeeds or fails, ends with enh_active 0 and active_code 0x00.
- R11: If start and terminate requests arrive together while idle, the terminate request wins, and data_out is left unchanged.
- R12: One tick lasts tick_div+1 clock cycles, and every timed window above scales with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div | input | DIV_W | Tick period minus one, in clock cycles |
| start_req | input | 1 | Start a negotiation (sampled when idle) |
| mode_code | input | 8 | Requested mode code |
| term_req | input | 1 | Start a termination (sampled when idle) |
| st_nack | input | 1 | Peripheral nAck level |
| st_busy | input | 1 | Peripheral Busy level |
| st_perror | input | 1 | Peripheral PError level |
| st_select | input | 1 | Peripheral Select level |
| st_nfault | input | 1 | Peripheral nFault level |
| n_strobe | output | 1 | Host nStrobe line |
| n_autofd | output | 1 | Host nAutoFd line |
| n_init | output | 1 | Host nInit line |
| n_selectin | output | 1 | Host nSelectIn line |
| data_out | output | 8 | Host-driven data bus |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 1 ok, 2 rejected, 3 timeout, 4 protocol error, 5 refused |
| enh_active | output | 1 | An enhanced mode is in force |
| active_code | output | 8 | Code of the mode in force (0x00 when none) |

## Verification
The assertions assume three things about the inputs. The status lines are already synchronous to `clk`. `tick_div` does not change while `busy` is 1. A request is only looked at in an idle cycle. The bench follows these rules: it changes status lines and requests only on falling clock edges, it sets `tick_div` only between operations, and it raises each request for exactly one cycle while the block is idle. Its peripheral model reacts to the control lines it observes, so each status change follows the host event that allows it.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_RESP, PH_STROBE, PH_ACKW, PH_TERM1, PH_TERM2
    } phase_e;

    typedef enum logic [2:0] {
        RES_NONE    = 3'd0,
        RES_OK      = 3'd1,
        RES_REJECT  = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_PROTO   = 3'd4,
        RES_REFUSED = 3'd5
    } res_e;

    // wire levels of the host control lines
    typedef struct packed {
        logic stb;
        logic afd;
        logic init;
        logic sel;
    } pins_t;

    localparam pins_t PINS_IDLE = '{stb: 1'b1, afd: 1'b1, init: 1'b1, sel: 1'b0};

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ppm_tick_gen.sv
module ppm_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == div);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ppm_status_eval.sv
module ppm_status_eval (
    input  logic st_nack,
    input  logic st_busy,
    input  logic st_perror,
    input  logic st_select,
    input  logic st_nfault,
    output logic resp_seen,
    output logic nack_high,
    output logic term_seen
);
    // peripheral answers the mode request as an enhanced-capable device
    assign resp_seen = st_perror && st_select && st_nfault && !st_nack;
    assign nack_high = st_nack;
    // peripheral acknowledges the termination request
    assign term_seen = st_busy && st_nfault && !st_nack;
endmodule

// File: rtl/ppm_negotiator.sv
module ppm_negotiator
    import ppm_pkg::*;
#(
    parameter int DIV_W        = 16,
    parameter int SETUP_TICKS  = 1,
    parameter int RESP_TICKS   = 6,
    parameter int STROBE_TICKS = 1,
    parameter int ACK_TICKS    = 7,
    parameter int TERM1_TICKS  = 7,
    parameter int TERM2_TICKS  = 6,
    parameter logic [7:0] NIBBLE_CODE = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] tick_div,
    input  logic             start_req,
    input  logic [7:0]       mode_code,
    input  logic             term_req,
    input  logic             st_nack,
    input  logic             st_busy,
    input  logic             st_perror,
    input  logic             st_select,
    input  logic             st_nfault,
    output logic             n_strobe,
    output logic             n_autofd,
    output logic             n_init,
    output logic             n_selectin,
    output logic [7:0]       data_out,
    output logic             busy,
    output logic             done,
    output logic [2:0]       result,
    output logic             enh_active,
    output logic [7:0]       active_code
);
    localparam int MAX_TICKS = max_of(max_of(max_of(SETUP_TICKS, RESP_TICKS),
                                             max_of(STROBE_TICKS, ACK_TICKS)),
                                      max_of(TERM1_TICKS, TERM2_TICKS));
    localparam int TCNT_W = $clog2(MAX_TICKS + 1);
    localparam logic [TCNT_W-1:0] LIM_SETUP  = TCNT_W'(SETUP_TICKS - 1);
    localparam logic [TCNT_W-1:0] LIM_RESP   = TCNT_W'(RESP_TICKS - 1);
    localparam logic [TCNT_W-1:0] LIM_STROBE = TCNT_W'(STROBE_TICKS - 1);
    localparam logic [TCNT_W-1:0] LIM_ACK    = TCNT_W'(ACK_TICKS - 1);
    localparam logic [TCNT_W-1:0] LIM_TERM1  = TCNT_W'(TERM1_TICKS - 1);
    localparam logic [TCNT_W-1:0] LIM_TERM2  = TCNT_W'(TERM2_TICKS - 1);

    typedef struct packed {
        phase_e            phase;
        pins_t             pins;
        logic [7:0]        data;
        logic [TCNT_W-1:0] tcnt;
        logic              done;
        res_e              res;
        logic              enh;
        logic [7:0]        code;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick, tick_clr;
    logic  resp_seen, nack_high, term_seen;

    ppm_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk (clk),
        .rst_n (rst_n),
        .clr (tick_clr),
        .div (tick_div),
        .tick (tick)
    );

    ppm_status_eval eval_i (
        .st_nack (st_nack),
        .st_busy (st_busy),
        .st_perror (st_perror),
        .st_select (st_select),
        .st_nfault (st_nfault),
        .resp_seen (resp_seen),
        .nack_high (nack_high),
        .term_seen (term_seen)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (term_req) begin
                    r_d.pins  = PINS_IDLE;
                    r_d.phase = PH_TERM1;
                end else if (start_req) begin
                    if (r_q.pins.sel) begin
                        r_d.done = 1'b1;
                        r_d.res  = RES_REFUSED;
                    end else begin
                        r_d.data  = mode_code;
                        r_d.phase = PH_SETUP;
                    end
                end
            end
            PH_SETUP: begin
                if (tick && r_q.tcnt == LIM_SETUP) begin
                    r_d.pins.sel = 1'b1;
                    r_d.pins.afd = 1'b0;
                    r_d.phase    = PH_RESP;
                end
            end
            PH_RESP: begin
                if (resp_seen) begin
                    r_d.pins.stb = 1'b0;
                    r_d.phase    = PH_STROBE;
                end else if (tick && r_q.tcnt == LIM_RESP) begin
                    r_d.pins  = PINS_IDLE;
                    r_d.done  = 1'b1;
                    r_d.res   = RES_TIMEOUT;
                    r_d.phase = PH_IDLE;
                end
            end
            PH_STROBE: begin
                if (tick && r_q.tcnt == LIM_STROBE) begin
                    r_d.pins.stb = 1'b1;
                    r_d.pins.afd = 1'b1;
                    r_d.phase    = PH_ACKW;
                end
            end
            PH_ACKW: begin
                if (nack_high) begin
                    r_d.done  = 1'b1;
                    r_d.phase = PH_IDLE;
                    if (r_q.data == NIBBLE_CODE || st_select) begin
                        r_d.res  = RES_OK;
                        r_d.enh  = 1'b1;
                        r_d.code = r_q.data;
                    end else begin
                        r_d.res  = RES_REJECT;
                        r_d.pins = PINS_IDLE;
                    end
                end else if (tick && r_q.tcnt == LIM_ACK) begin
                    r_d.pins  = PINS_IDLE;
                    r_d.done  = 1'b1;
                    r_d.res   = RES_PROTO;
                    r_d.phase = PH_IDLE;
                end
            end
            PH_TERM1: begin
                if (term_seen) begin
                    r_d.pins.afd = 1'b0;
                    r_d.phase    = PH_TERM2;
                end else if (tick && r_q.tcnt == LIM_TERM1) begin
                    r_d.done  = 1'b1;
                    r_d.res   = RES_PROTO;
                    r_d.enh   = 1'b0;
                    r_d.code  = '0;
                    r_d.phase = PH_IDLE;
                end
            end
            PH_TERM2: begin
                if (nack_high || (tick && r_q.tcnt == LIM_TERM2)) begin
                    r_d.pins.afd = 1'b1;
                    r_d.done     = 1'b1;
                    r_d.res      = nack_high ? RES_OK : RES_PROTO;
                    r_d.enh      = 1'b0;
                    r_d.code     = '0;
                    r_d.phase    = PH_IDLE;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase

        if (r_d.phase != r_q.phase)      r_d.tcnt = '0;
        else if (tick && r_q.phase != PH_IDLE) r_d.tcnt = r_q.tcnt + 1'b1;
    end

    assign tick_clr = (r_d.phase != r_q.phase);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
            r_q.pins  <= PINS_IDLE;
            r_q.res   <= RES_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign n_strobe    = r_q.pins.stb;
    assign n_autofd    = r_q.pins.afd;
    assign n_init      = r_q.pins.init;
    assign n_selectin  = r_q.pins.sel;
    assign data_out    = r_q.data;
    assign busy        = (r_q.phase != PH_IDLE);
    assign done        = r_q.done;
    assign result      = r_q.res;
    assign enh_active  = r_q.enh;
    assign active_code = r_q.code;

    AST_REFUSE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !term_req && start_req && n_selectin) |=> (done && result == RES_REFUSED && n_selectin)); // R2
    AST_RESP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_RESP) |-> (r_q.tcnt < TCNT_W'(RESP_TICKS))); // R4
    AST_STROBE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !n_strobe |-> (n_selectin && !n_autofd)); // R5
    AST_ENH_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enh_active) |-> (done && result == RES_OK)); // R7
    AST_DONE_AUTOFD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (n_autofd && n_strobe)); // R9
    AST_TERM_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(r_q.phase) == PH_TERM1 || $past(r_q.phase) == PH_TERM2))
        |-> (!enh_active && active_code == 8'h00)); // R10
endmodule

// File: tb/ppm_negotiator_tb.sv
module ppm_negotiator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tick_div = 16'd3;
    logic        start_req = 1'b0, term_req = 1'b0;
    logic [7:0]  mode_code = 8'h00;
    logic        st_nack = 1'b1, st_busy = 1'b0, st_perror = 1'b0;
    logic        st_select = 1'b1, st_nfault = 1'b1;
    logic        n_strobe, n_autofd, n_init, n_selectin, busy, done, enh_active;
    logic [7:0]  data_out, active_code;
    logic [2:0]  result;

    int errors = 0, checks = 0;
    bit finished = 1'b0;
    logic [11:0] sb_q[$];

    always #2 clk = ~clk;

    ppm_negotiator dut_i (
        .clk(clk), .rst_n(rst_n), .tick_div(tick_div),
        .start_req(start_req), .mode_code(mode_code), .term_req(term_req),
        .st_nack(st_nack), .st_busy(st_busy), .st_perror(st_perror),
        .st_select(st_select), .st_nfault(st_nfault),
        .n_strobe(n_strobe), .n_autofd(n_autofd), .n_init(n_init),
        .n_selectin(n_selectin), .data_out(data_out), .busy(busy),
        .done(done), .result(result), .enh_active(enh_active),
        .active_code(active_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic periph_idle();
        st_nack = 1'b1; st_busy = 1'b0; st_perror = 1'b0; st_select = 1'b1; st_nfault = 1'b1;
    endtask

    // monitor: compare each completion with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                logic [11:0] e;
                e = sb_q.pop_front();
                check({result, enh_active, active_code} == e, "R7 R10 completion",
                      int'({result, enh_active, active_code}), int'(e));
            end
        end
    end

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 2000) begin step(); n++; end
    endtask

    task automatic negotiate(input logic [7:0] code, input bit resp, input bit accept,
                             input bit ack, input logic [2:0] exp_res);
        int n;
        int per;
        per = int'(tick_div) + 1;
        sb_q.push_back({exp_res, (exp_res == 3'd1), (exp_res == 3'd1) ? code : 8'h00});
        start_req = 1'b1; mode_code = code;
        step();
        start_req = 1'b0;
        check(data_out == code, "R3 code on bus", data_out, code);
        n = 0;
        while (!n_selectin && n < 500) begin step(); n++; end
        check(n == per, "R3 R12 setup length", n, per);
        check(!n_autofd && n_strobe && n_init, "R3 event pins", {n_strobe, n_autofd, n_init}, 5);
        if (!resp) begin
            wait_done(n);
            check(n == 6 * per, "R4 R12 timeout window", n, 6 * per);
            check(!n_selectin && n_autofd, "R4 idle after timeout", {n_selectin, n_autofd}, 1);
        end else begin
            st_perror = 1'b1; st_select = 1'b1; st_nfault = 1'b1; st_nack = 1'b0;
            n = 0;
            while (n_strobe && n < 500) begin step(); n++; end
            check(n == 1, "R5 strobe start", n, 1);
            n = 0;
            while (!n_strobe && n < 500) begin step(); n++; end
            check(n == per, "R5 strobe width", n, per);
            check(n_autofd, "R5 autofd restored", n_autofd, 1);
            st_select = accept;
            if (ack) st_nack = 1'b1;
            wait_done(n);
            if (ack) check(n == 1, "R7 decision latency", n, 1);
            else     check(n == 7 * per, "R6 ack window", n, 7 * per);
            check(n_selectin == (exp_res == 3'd1), "R7 selectin after", n_selectin, exp_res == 3'd1);
        end
        step();
        check(!busy, "R7 idle", busy, 0);
        periph_idle();
    endtask

    task automatic terminate(input bit ok1, input bit ok2, input bit with_start,
                             input logic [2:0] exp_res);
        int n;
        int per;
        logic [7:0] old_data;
        per = int'(tick_div) + 1;
        old_data = data_out;
        sb_q.push_back({exp_res, 1'b0, 8'h00});
        term_req = 1'b1;
        if (with_start) begin start_req = 1'b1; mode_code = 8'h30; end
        step();
        term_req = 1'b0; start_req = 1'b0;
        check(!n_selectin && n_autofd && n_strobe && n_init, "R8 term pins",
              {n_selectin, n_autofd, n_strobe, n_init}, 7);
        if (with_start) check(data_out == old_data, "R11 data untouched", data_out, old_data);
        if (!ok1) begin
            wait_done(n);
            check(n == 7 * per - 1 + 1, "R8 R12 term window", n + 1, 7 * per);
        end else begin
            st_busy = 1'b1; st_nfault = 1'b1; st_nack = 1'b0;
            n = 0;
            while (n_autofd && n < 500) begin step(); n++; end
            check(n == 1, "R9 autofd low", n, 1);
            if (ok2) st_nack = 1'b1;
            wait_done(n);
            if (ok2) check(n == 1, "R9 finish latency", n, 1);
            else     check(n == 6 * per, "R9 second window", n, 6 * per);
        end
        check(n_autofd && !n_selectin, "R9 autofd high at end", {n_autofd, n_selectin}, 2);
        check(!enh_active && active_code == 8'h00, "R10 mode cleared", enh_active, 0);
        step();
        periph_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(n_strobe && n_autofd && n_init && !n_selectin, "R1 reset pins",
              {n_strobe, n_autofd, n_init, n_selectin}, 14);
        check(data_out == 8'h00 && !busy && !done && !enh_active, "R1 reset state",
              {data_out, busy, done, enh_active}, 0);

        negotiate(8'h00, 1, 0, 1, 3'd1);            // R7 nibble accepted without Select
        begin : refuse
            sb_q.push_back({3'd5, 1'b1, 8'h00});
            start_req = 1'b1; mode_code = 8'h30;
            step();
            start_req = 1'b0;
            check(done && result == 3'd5, "R2 refused next cycle", result, 5);
            check(n_selectin && !busy, "R2 lines unchanged", {n_selectin, busy}, 2);
            step();
        end
        terminate(1, 1, 0, 3'd1);                   // R8 R9 R10 clean return
        negotiate(8'h30, 1, 1, 1, 3'd1);            // R7 enhanced code accepted
        terminate(1, 0, 0, 3'd4);                   // R9 second wait fails
        negotiate(8'h30, 1, 0, 1, 3'd2);            // R7 rejected
        negotiate(8'h30, 0, 0, 0, 3'd3);            // R4 no response
        negotiate(8'h10, 1, 1, 0, 3'd4);            // R6 nAck never rises
        terminate(0, 0, 0, 3'd4);                   // R8 first wait fails
        tick_div = 16'd1;
        negotiate(8'h30, 0, 0, 0, 3'd3);            // R12 shorter tick
        tick_div = 16'd5;
        negotiate(8'h00, 1, 0, 1, 3'd1);            // R12 longer tick
        terminate(1, 1, 1, 3'd1);                   // R11 terminate wins over start
        check(sb_q.size() == 0, "R7 all completions seen", sb_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule